// File: doc/BRIEF.md
# SPI-to-NAND Bridge Command Decoder

This block is an SPI slave that lets a host on a plain SPI bus drive a raw 8-bit NAND flash and a small output port of LEDs and a fan enable. Every chip-select frame begins with a one-byte command. That command chooses one of five actions: push bytes onto the NAND data bus, pull bytes off it, load an output configuration register, or switch a fifth LED on or off. For NAND writes, a second data-in pin carries every other bit, so a data byte needs only four SCK periods.

All SPI pins are sampled by the system clock through a synchronizer. SCK must therefore be much slower than the system clock, with each SCK half period at least 10 system clocks. The NAND strobes are generated in the system clock domain as single pulses with a fixed minimum width. ECC, ready/busy sensing and multi-phase NAND timing belong to the host.

Top module: `spi_nand_bridge`

## Requirements
- R1: After reset the configuration register holds 0x8F: nand_ce_n=1, nand_cle=0, nand_ale=0, fan_on=0, led_n=4'hF. Also aux_led=0, nand_we_n=1, nand_re_n=1 and nand_doe=0.
- R2: The SPI link runs in mode 0. Bytes are 8 bits, most significant bit first. MOSI is sampled on the rising edge of SCK and MISO changes on the falling edge. The first byte of every frame is the command code.
- R3: Command 0x09 copies the next byte into the configuration register, which drives the outputs as follows: bit 7 drives nand_ce_n, bit 6 drives nand_cle, bit 5 drives nand_ale, bit 4 drives fan_on, and bits 3..0 drive led_n[3:0] (active low). Any further bytes in that frame are ignored.
- R4: Command 0x08 starts a NAND write. Every later byte arrives as four bit pairs, one pair per SCK rise: the higher bit on spi_mosi and the lower bit on spi_mosi_aux. A data byte is put on nand_dout with one nWE pulse when the following byte completes, so the frame must end with one trailing idle byte, which is never written. nand_doe is high whenever nWE is low.
- R5: Command 0x0A starts a NAND read. One idle byte follows the command. Each later byte slot returns one NAND byte on MISO. A frame with n data slots produces n+1 nRE pulses, because one byte is fetched ahead.
- R6: Command 0x0B is a fast read. It is followed by three address bytes and one dummy byte. No nRE pulse occurs during the address bytes. From then on it behaves like R5, with n data slots giving n+1 nRE pulses.
- R7: Command 0x0C sets aux_led to 1 and command 0x0D clears it to 0. The rest of that frame is ignored.
- R8: Raising spi_cs_n aborts the current command at once. A partial byte is discarded, a write byte still waiting for its strobe is dropped, and the next frame's first byte is decoded as a command.
- R9: Any other command code leaves every output unchanged until the frame ends.
- R10: Each NAND strobe stays low for at least two system clocks. nWE and nRE are never low together. A strobe that has started runs to its full width even if the frame is aborted.
- R11: The byte read from nand_din is captured at the end of the nRE pulse. It is shifted out MSB first in the next MISO byte slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| spi_sck | input | 1 | SPI serial clock from host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Host data in; upper bit of a pair in write frames |
| spi_mosi_aux | input | 1 | Second data-in pin; lower bit of a pair in write frames |
| spi_miso | output | 1 | Slave data out |
| nand_dout | output | 8 | Byte driven to the NAND I/O bus |
| nand_doe | output | 1 | Output enable for nand_dout |
| nand_din | input | 8 | Byte read from the NAND I/O bus |
| nand_ce_n | output | 1 | NAND chip enable, active low (config bit 7) |
| nand_cle | output | 1 | NAND command latch enable (config bit 6) |
| nand_ale | output | 1 | NAND address latch enable (config bit 5) |
| nand_we_n | output | 1 | NAND write strobe, active low |
| nand_re_n | output | 1 | NAND read strobe, active low |
| led_n | output | 4 | Four LEDs, active low (config bits 3..0) |
| fan_on | output | 1 | Fan enable (config bit 4) |
| aux_led | output | 1 | Fifth LED, 1 = lit |

## Verification
A frame abort and a write strobe can overlap in the same cycles. If chip select is released right after the SCK rise that completes the trailing idle byte, the decoder drops back to command wait while the nWE pulse for the last data byte is still low. The bench provokes this by raising spi_cs_n two system clocks after that SCK rise. A NAND model in the bench then checks three things: the pulse kept its full width, nand_doe stayed high throughout it, and the latched byte matches the one queued by the driver. Read prefetch and MISO shifting are judged the same way, with each returned byte compared against a deterministic NAND data pattern indexed by the bench's own count of reads.

// File: rtl/spi_nand_bridge_pkg.sv
// Shared constants and types for the SPI-to-NAND bridge.
// Holds the command codes, the configuration bit positions, the config
// reset value and the decoder state type.
package spi_nand_bridge_pkg;

    localparam logic [7:0] CMD_NAND_WRITE = 8'h08;
    localparam logic [7:0] CMD_LOAD_CFG   = 8'h09;
    localparam logic [7:0] CMD_NAND_READ  = 8'h0A;
    localparam logic [7:0] CMD_FAST_READ  = 8'h0B;
    localparam logic [7:0] CMD_AUX_ON     = 8'h0C;
    localparam logic [7:0] CMD_AUX_OFF    = 8'h0D;

    // Configuration register bit positions; the output pins decode these.
    localparam int CFG_CE_N_BIT = 7;
    localparam int CFG_CLE_BIT  = 6;
    localparam int CFG_ALE_BIT  = 5;
    localparam int CFG_FAN_BIT  = 4;

    // Chip disabled, LEDs dark, latches and fan off.
    localparam logic [7:0] CFG_RESET = 8'h8F;

    typedef enum logic [2:0] {
        S_COMMAND,
        S_WRITE,
        S_CONFIG,
        S_READ,
        S_DISCARD
    } dec_state_t;

endpackage

// File: rtl/bridge_pin_sync.sv
// Pin front end: brings SCK, CS, MOSI and the second data pin into the
// system clock domain and produces single-cycle SCK edge strobes.
// Assumes SCK half period is several system clocks; all four pins pass
// through the same number of stages, so their relative order is kept.
module bridge_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    input  logic spi_mosi_aux,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_act,
    output logic mosi_s,
    output logic aux_s
);
    localparam int CHAIN_W = 4 * SYNC_STAGES;
    localparam logic [3:0] PINS_IDLE = 4'b0100;

    logic [CHAIN_W-1:0] chain;
    logic [3:0]         last;
    logic [3:0]         prev;

    // Shift the pin vector {sck, cs_n, mosi, aux} through the stages.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {SYNC_STAGES{PINS_IDLE}};
        else        chain <= {chain[CHAIN_W-5:0], spi_sck, spi_cs_n, spi_mosi, spi_mosi_aux};
    end

    assign last = chain[CHAIN_W-1 -: 4];

    // Hold the previous synchronized value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= PINS_IDLE;
        else        prev <= last;
    end

    assign cs_act   = !last[2];
    assign sck_rise = cs_act && last[3] && !prev[3];
    assign sck_fall = cs_act && !last[3] && prev[3];
    assign mosi_s   = last[1];
    assign aux_s    = last[0];

endmodule

// File: rtl/bridge_shift.sv
// Serial shifters: assembles received bytes (one or two bits per SCK
// rise) and shifts the reply byte out on MISO at SCK falls.
// Assumes mode 0; a new reply byte is loaded at every eighth fall.
module bridge_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_act,
    input  logic       sck_rise,
    input  logic       sck_fall,
    input  logic       mosi_s,
    input  logic       aux_s,
    input  logic       dual,
    input  logic [7:0] load_val,
    output logic       byte_valid,
    output logic [7:0] byte_data,
    output logic       load_take,
    output logic       miso
);
    logic [2:0] rx_cnt;
    logic [7:0] rx_sr;
    logic [2:0] tx_cnt;
    logic [7:0] tx_sr;

    // Receive: gather bits, flag a whole byte for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            rx_cnt     <= '0;
            rx_sr      <= '0;
            byte_valid <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            if (sck_rise) begin
                if (dual) begin
                    rx_sr      <= {rx_sr[5:0], mosi_s, aux_s};
                    rx_cnt     <= rx_cnt + 3'd2;
                    byte_valid <= (rx_cnt == 3'd6);
                end else begin
                    rx_sr      <= {rx_sr[6:0], mosi_s};
                    rx_cnt     <= rx_cnt + 3'd1;
                    byte_valid <= (rx_cnt == 3'd7);
                end
            end
        end
    end

    assign byte_data = rx_sr;

    // Transmit: shift on falls, reload at the byte boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            tx_cnt    <= '0;
            tx_sr     <= '0;
            load_take <= 1'b0;
        end else begin
            load_take <= 1'b0;
            if (sck_fall) begin
                tx_cnt <= tx_cnt + 3'd1;
                if (tx_cnt == 3'd7) begin
                    tx_sr     <= load_val;
                    load_take <= 1'b1;
                end else begin
                    tx_sr <= {tx_sr[6:0], 1'b0};
                end
            end
        end
    end

    assign miso = tx_sr[7];

    p_valid_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

endmodule

// File: rtl/bridge_strobe.sv
// One NAND strobe: on a go pulse it spends one setup cycle, then holds
// the active-low strobe for LOW_CYC cycles. done marks the last low cycle
// (the data capture point). It runs to completion once started.
module bridge_strobe #(
    parameter int LOW_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic strobe_n,
    output logic busy,
    output logic done
);
    localparam int CNT_W = (LOW_CYC < 2) ? 1 : $clog2(LOW_CYC);

    typedef enum logic [1:0] {P_IDLE, P_SETUP, P_LOW} phase_t;

    phase_t          phase;
    logic [CNT_W-1:0] cnt;

    // Sequence idle -> setup -> low (LOW_CYC cycles) -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= P_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                P_IDLE:  if (go) phase <= P_SETUP;
                P_SETUP: begin
                    phase <= P_LOW;
                    cnt   <= '0;
                end
                P_LOW: begin
                    if (cnt == CNT_W'(LOW_CYC - 1)) phase <= P_IDLE;
                    else                            cnt   <= cnt + 1'b1;
                end
                default: phase <= P_IDLE;
            endcase
        end
    end

    assign strobe_n = (phase != P_LOW);
    assign busy     = (phase != P_IDLE);
    assign done     = (phase == P_LOW) && (cnt == CNT_W'(LOW_CYC - 1));

    p_low_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe_n) |=> !strobe_n);

    p_go_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !busy);

endmodule

// File: rtl/bridge_ctrl.sv
// Command decoder: interprets the first byte of a frame, then routes
// later bytes to the NAND write path, the configuration register, the
// read-ahead path or nowhere. Assumes byte_valid pulses are far apart
// compared with a strobe, and that CS release resets the frame.
module bridge_ctrl
    import spi_nand_bridge_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int SKIP_W     = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_act,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    input  logic       load_take,
    input  logic       we_busy,
    input  logic       re_done,
    input  logic [7:0] nand_din,
    output logic       dual,
    output logic [7:0] tx_val,
    output logic       we_go,
    output logic       re_go,
    output logic [7:0] nand_dout,
    output logic       nand_doe,
    output logic [7:0] cfg,
    output logic       aux_led
);
    dec_state_t       st;
    logic [SKIP_W-1:0] skip;
    logic [7:0]       pend;
    logic             pend_v;
    logic [7:0]       wr_bus;
    logic [7:0]       rd_latch;
    logic             rd_ready;
    logic             take;

    assign take  = cs_act && byte_valid;
    assign we_go = take && (st == S_WRITE) && pend_v;
    assign re_go = take && (st == S_READ) && (skip <= SKIP_W'(1));

    // Decode the command byte and track the frame's phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_COMMAND;
            skip    <= '0;
            cfg     <= CFG_RESET;
            aux_led <= 1'b0;
        end else if (!cs_act) begin
            st   <= S_COMMAND;
            skip <= '0;
        end else if (byte_valid) begin
            case (st)
                S_COMMAND: begin
                    case (byte_data)
                        CMD_NAND_WRITE: st <= S_WRITE;
                        CMD_LOAD_CFG:   st <= S_CONFIG;
                        CMD_NAND_READ: begin
                            st   <= S_READ;
                            skip <= SKIP_W'(1);
                        end
                        CMD_FAST_READ: begin
                            st   <= S_READ;
                            skip <= SKIP_W'(ADDR_BYTES + 1);
                        end
                        CMD_AUX_ON: begin
                            aux_led <= 1'b1;
                            st      <= S_DISCARD;
                        end
                        CMD_AUX_OFF: begin
                            aux_led <= 1'b0;
                            st      <= S_DISCARD;
                        end
                        default: st <= S_DISCARD;
                    endcase
                end
                S_CONFIG: begin
                    cfg <= byte_data;
                    st  <= S_DISCARD;
                end
                S_READ: begin
                    if (skip != '0) skip <= skip - 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Hold each write byte until the next one proves the frame went on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend   <= '0;
            pend_v <= 1'b0;
            wr_bus <= '0;
        end else if (!cs_act) begin
            pend_v <= 1'b0;
        end else if (take && (st == S_WRITE)) begin
            pend   <= byte_data;
            pend_v <= 1'b1;
            if (pend_v) wr_bus <= pend;
        end
    end

    // Capture read data at the strobe end; release it to the shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_latch <= '0;
            rd_ready <= 1'b0;
        end else if (!cs_act) begin
            rd_ready <= 1'b0;
        end else if (re_done) begin
            rd_latch <= nand_din;
            rd_ready <= 1'b1;
        end else if (load_take) begin
            rd_ready <= 1'b0;
        end
    end

    assign dual      = (st == S_WRITE);
    assign tx_val    = rd_ready ? rd_latch : 8'h00;
    assign nand_dout = wr_bus;
    assign nand_doe  = (st == S_WRITE) || we_busy;

    p_cfg_only_by_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg) |-> $past(cs_act && byte_valid && st == S_CONFIG));

    p_aux_only_by_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(aux_led) |-> $past(cs_act && byte_valid && st == S_COMMAND));

    p_abort_to_command_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (st == S_COMMAND) && !pend_v);

endmodule

// File: rtl/spi_nand_bridge.sv
// Top of the SPI-to-NAND bridge: pin synchronizer, serial shifters,
// command decoder and two NAND strobe generators (write, read).
// Assumes SCK half period >= SYNC_STAGES + STROBE_LOW + 6 system clocks.
module spi_nand_bridge
    import spi_nand_bridge_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int STROBE_LOW  = 2,
    parameter int ADDR_BYTES  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_sck,
    input  logic       spi_cs_n,
    input  logic       spi_mosi,
    input  logic       spi_mosi_aux,
    output logic       spi_miso,
    output logic [7:0] nand_dout,
    output logic       nand_doe,
    input  logic [7:0] nand_din,
    output logic       nand_ce_n,
    output logic       nand_cle,
    output logic       nand_ale,
    output logic       nand_we_n,
    output logic       nand_re_n,
    output logic [3:0] led_n,
    output logic       fan_on,
    output logic       aux_led
);
    localparam int SKIP_W   = $clog2(ADDR_BYTES + 2);
    localparam int N_STROBE = 2;   // index 0: write, index 1: read

    logic       sck_rise, sck_fall, cs_act, mosi_s, aux_s;
    logic       byte_valid, load_take, dual;
    logic [7:0] byte_data, tx_val, cfg;
    logic [N_STROBE-1:0] sb_go, sb_n, sb_busy, sb_done;

    bridge_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_mosi_aux(spi_mosi_aux),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_act(cs_act),
        .mosi_s(mosi_s), .aux_s(aux_s)
    );

    bridge_shift u_shift (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act),
        .sck_rise(sck_rise), .sck_fall(sck_fall),
        .mosi_s(mosi_s), .aux_s(aux_s), .dual(dual),
        .load_val(tx_val), .byte_valid(byte_valid), .byte_data(byte_data),
        .load_take(load_take), .miso(spi_miso)
    );

    bridge_ctrl #(.ADDR_BYTES(ADDR_BYTES), .SKIP_W(SKIP_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .load_take(load_take), .we_busy(sb_busy[0]), .re_done(sb_done[1]),
        .nand_din(nand_din), .dual(dual), .tx_val(tx_val),
        .we_go(sb_go[0]), .re_go(sb_go[1]),
        .nand_dout(nand_dout), .nand_doe(nand_doe),
        .cfg(cfg), .aux_led(aux_led)
    );

    for (genvar g = 0; g < N_STROBE; g++) begin : g_strobe
        bridge_strobe #(.LOW_CYC(STROBE_LOW)) u_strobe (
            .clk(clk), .rst_n(rst_n), .go(sb_go[g]),
            .strobe_n(sb_n[g]), .busy(sb_busy[g]), .done(sb_done[g])
        );
    end

    assign nand_we_n = sb_n[0];
    assign nand_re_n = sb_n[1];
    assign nand_ce_n = cfg[CFG_CE_N_BIT];
    assign nand_cle  = cfg[CFG_CLE_BIT];
    assign nand_ale  = cfg[CFG_ALE_BIT];
    assign fan_on    = cfg[CFG_FAN_BIT];
    assign led_n     = cfg[3:0];

    p_strobes_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        nand_we_n || nand_re_n);

    p_no_double_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(sb_busy[0] && sb_busy[1]));

    p_we_ends_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sb_done[0] |=> nand_we_n);

    p_bus_driven_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> nand_doe);

endmodule

// File: tb/test_spi_nand_bridge.sv
`timescale 1ns/1ps
module test_spi_nand_bridge;
    localparam int HALF = 10;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0, spi_mosi_aux = 1'b0;
    logic spi_miso;
    logic [7:0] nand_dout, nand_din;
    logic nand_doe, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n;
    logic [3:0] led_n;
    logic fan_on, aux_led;

    int total = 0, bad = 0;
    int we_cnt = 0, rd_base = 0;
    logic [7:0] re_cnt = 8'd0;
    logic [7:0] exp_wr[$];

    always #2.5 clk = ~clk;

    spi_nand_bridge i_spi_nand_bridge (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_mosi_aux(spi_mosi_aux), .spi_miso(spi_miso),
        .nand_dout(nand_dout), .nand_doe(nand_doe), .nand_din(nand_din),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .led_n(led_n),
        .fan_on(fan_on), .aux_led(aux_led)
    );

    function automatic logic [7:0] pattern(input logic [7:0] k);
        return 8'h3C ^ (k * 8'd29);
    endfunction

    assign nand_din = pattern(re_cnt);

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // NAND model / scoreboard monitor: judges every write and read strobe.
    int  we_low = 0;
    logic we_prev = 1'b1, re_prev = 1'b1, doe_ok = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!nand_we_n) begin
                we_low++;
                if (!nand_doe) doe_ok = 1'b0;
            end
            if (we_prev == 1'b0 && nand_we_n == 1'b1) begin
                we_cnt++;
                check("R10 nWE low width>=2", (we_low >= 2) ? 1 : 0, 1);
                check("R4 nand_doe held during nWE", doe_ok ? 1 : 0, 1);
                if (exp_wr.size() == 0) begin
                    check("R4 unexpected NAND write", nand_dout, 256);
                end else begin
                    check("R4 NAND write data", nand_dout, exp_wr.pop_front());
                end
                we_low = 0;
                doe_ok = 1'b1;
            end
            if (re_prev == 1'b0 && nand_re_n == 1'b1) re_cnt = re_cnt + 8'd1;
            we_prev = nand_we_n;
            re_prev = nand_re_n;
        end
    end

    task automatic spi_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            spi_mosi = tx[i];
            wait_clk(HALF);
            spi_sck = 1'b1;
            rx[i] = spi_miso;
            wait_clk(HALF);
            spi_sck = 1'b0;
        end
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        spi_bits(tx, 8, rx);
    endtask

    task automatic spi_dual(input logic [7:0] tx, input bit early_release);
        for (int k = 0; k < 4; k++) begin
            spi_mosi     = tx[7 - 2 * k];
            spi_mosi_aux = tx[6 - 2 * k];
            wait_clk(HALF);
            spi_sck = 1'b1;
            if (early_release && k == 3) begin
                wait_clk(2);
                spi_cs_n = 1'b1;
                wait_clk(HALF - 2);
            end else begin
                wait_clk(HALF);
            end
            spi_sck = 1'b0;
        end
    endtask

    task automatic cs_begin();
        spi_cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_end();
        wait_clk(HALF);
        spi_cs_n = 1'b1;
        wait_clk(4 * HALF);
    endtask

    task automatic frame2(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] rx;
        cs_begin();
        spi_byte(a, rx);
        spi_byte(b, rx);
        cs_end();
    endtask

    // Driver: write frame; queues the bytes the NAND must see.
    task automatic wr_frame(input int n, input logic [7:0] seed, input bit with_idle);
        logic [7:0] rx;
        cs_begin();
        spi_byte(8'h08, rx);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = seed + 8'(i * 71);
            if (with_idle || i < n - 1) exp_wr.push_back(b);
            spi_dual(b, 1'b0);
        end
        if (with_idle) spi_dual(8'h00, 1'b0);
        cs_end();
    endtask

    task automatic rd_frame(input logic [7:0] op, input int n);
        logic [7:0] rx;
        int start;
        start = re_cnt;
        cs_begin();
        spi_byte(op, rx);
        if (op == 8'h0B) begin
            spi_byte(8'h12, rx);
            spi_byte(8'h34, rx);
            spi_byte(8'h56, rx);
            check("R6 no nRE during address bytes", int'(re_cnt) - start, 0);
        end
        spi_byte(8'h00, rx);
        for (int k = 0; k < n; k++) begin
            spi_byte(8'hFF, rx);
            check((op == 8'h0B) ? "R6 R11 fast read byte" : "R5 R11 read byte",
                  rx, pattern(8'(rd_base + k)));
        end
        cs_end();
        check((op == 8'h0B) ? "R6 nRE pulse count" : "R5 nRE pulse count",
              int'(re_cnt) - start, n + 1);
        rd_base += n + 1;
    endtask

    initial begin : watchdog
        wait_clk(WATCHDOG);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [7:0] rx;
        int w0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);

        // R1 reset state
        check("R1 config outputs", {nand_ce_n, nand_cle, nand_ale, fan_on, led_n}, 8'h8F);
        check("R1 strobes idle", {nand_we_n, nand_re_n}, 2'b11);
        check("R1 aux_led off", aux_led, 0);
        check("R1 bus not driven", nand_doe, 0);

        // R3 config load, trailing byte ignored
        cs_begin();
        spi_byte(8'h09, rx);
        spi_byte(8'hA6, rx);
        spi_byte(8'h33, rx);
        cs_end();
        check("R3 config bit map", {nand_ce_n, nand_cle, nand_ale, fan_on, led_n}, 8'hA6);

        // R8 abort mid config byte, then new command decoded
        cs_begin();
        spi_byte(8'h09, rx);
        spi_bits(8'h11, 4, rx);
        cs_end();
        check("R8 partial config byte discarded", {nand_ce_n, nand_cle, nand_ale, fan_on, led_n}, 8'hA6);
        frame2(8'h0C, 8'h0D);
        check("R7 R8 aux on after abort, tail ignored", aux_led, 1);
        frame2(8'h0D, 8'h0C);
        check("R7 aux off, tail ignored", aux_led, 0);

        // R9 undefined command
        w0 = we_cnt;
        cs_begin();
        spi_byte(8'h33, rx);
        spi_byte(8'h0C, rx);
        spi_byte(8'h09, rx);
        spi_byte(8'hFF, rx);
        cs_end();
        check("R9 aux unchanged", aux_led, 0);
        check("R9 config unchanged", {nand_ce_n, nand_cle, nand_ale, fan_on, led_n}, 8'hA6);
        check("R9 no strobe", we_cnt - w0, 0);

        // R4 dual-bit write with idle byte
        w0 = we_cnt;
        wr_frame(3, 8'h5B, 1'b1);
        check("R4 three bytes written", we_cnt - w0, 3);

        // R4 R8 write without idle: last byte dropped
        w0 = we_cnt;
        wr_frame(2, 8'hC1, 1'b0);
        check("R8 unfinished write dropped", we_cnt - w0, 1);

        // R5 R11 plain read, R6 fast read
        rd_frame(8'h0A, 3);
        rd_frame(8'h0B, 2);

        // R10 abort lands while the last nWE pulse runs
        w0 = we_cnt;
        cs_begin();
        spi_byte(8'h08, rx);
        exp_wr.push_back(8'h9E);
        spi_dual(8'h9E, 1'b0);
        spi_dual(8'h00, 1'b1);
        wait_clk(4 * HALF);
        check("R10 strobe completes across abort", we_cnt - w0, 1);
        check("R8 bus released after abort", nand_doe, 0);

        check("R4 write queue drained", exp_wr.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule